// File: doc/BRIEF.md
# Prioritised Interrupt Entry Controller

This block holds the pending and enable state for a processor's reset event, its non-maskable interrupt and the twelve maskable lines numbered 4 to 15. Each cycle it looks at the pending lines that are allowed to be taken and picks one. It then carries out the entry: it retires that pending bit, saves the return address, drops the global enable if the line is maskable, and sends the processor a vector address inside a table that software can relocate.

Software reaches the state through strobed register writes and plain read buses. The pending register has no direct write port. Bits are raised through a set strobe and retired through a clear strobe. The non-maskable enable bit is write-once, and the whole maskable group stays closed until it is set. A return strobe brings the global enable back from its saved copy. Sources arrive as already-qualified one-cycle pulses, and the core supplies the address of the next instruction to execute.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the pending register reads 0, the enable register reads 0x0001, the status bus reads 00, the table read bus reads 0, and take and ack are low.
- R2: The enable read bus has bit 0 fixed at 1, bit 1 as the NMI enable, bits 2 and 3 reading 0, and bits 4 to 15 as the line enables written through the enable strobe. A status write never alters the enable read bus.
- R3: Once the NMI enable bit (enable bit 1) is 1, it stays 1 whatever later enable writes carry.
- R4: A maskable line i is taken only when pending bit i, enable bit i, the global enable (status bit 0) and the NMI enable are all 1 in the cycle before take rises.
- R5: A pending bit becomes 1 on the clock edge that follows a hardware pulse on its line or a set-strobe write with a 1 in that position. It becomes 0 on the edge after a clear-strobe write with a 1 there. Software writes do not touch bits 0, 2 and 3.
- R6: When a hardware pulse and a clear write hit the same pending bit in the same cycle, the bit ends at 1.
- R7: Taking a maskable line retires its pending bit, sets the saved enable (status bit 1) to the old global enable, clears the global enable, and loads the maskable return pointer with the next-execute address. All of this appears together with take, one edge after the line became eligible.
- R8: Taking the NMI (number 1) loads the NMI return pointer and leaves the maskable return pointer and both status bits unchanged. Taking the reset event (number 0) changes neither return pointer.
- R9: The table read bus returns the written table address with bits 9:0 forced to 0. The vector equals that base plus 0x20 times the interrupt number, using the base held in the cycle before take.
- R10: Each entry raises take and ack for exactly one cycle and drives the 4-bit number of the entry on irq_num.
- R11: Priority is reset (0), then NMI (1), then lines 4 to 15 with the lowest number first, and at most one entry is taken per cycle.
- R12: A return strobe copies the saved enable into the global enable on the next edge, unless an entry or a status write happens on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hw_req | input | 16 | Qualified one-cycle event pulses, one per interrupt number |
| wr_en | input | 1 | Enable register write strobe |
| en_wdata | input | 16 | Enable register write data |
| wr_set | input | 1 | Set-register write strobe |
| set_wdata | input | 16 | Pending bits to raise |
| wr_clr | input | 1 | Clear-register write strobe |
| clr_wdata | input | 16 | Pending bits to retire |
| wr_stat | input | 1 | Status write strobe |
| stat_wdata | input | 2 | Bit 0 global enable, bit 1 saved enable |
| wr_tbl | input | 1 | Table pointer write strobe |
| tbl_wdata | input | 32 | Table pointer write data |
| rti | input | 1 | Return-from-interrupt strobe |
| nxt_addr | input | 32 | Address of the next instruction to execute |
| flag_rd | output | 16 | Pending register read bus |
| en_rd | output | 16 | Enable register read bus |
| stat_rd | output | 2 | Bit 0 global enable, bit 1 saved enable |
| tbl_rd | output | 32 | Table pointer read bus |
| take | output | 1 | Entry strobe to the core |
| vec_pc | output | 32 | Vector address to load into the program counter |
| ret_m | output | 32 | Maskable return pointer |
| ret_n | output | 32 | NMI return pointer |
| ack | output | 1 | Acknowledge pulse |
| irq_num | output | 4 | Number of the entry being taken |

## Verification
Two things can land on one pending bit in the same cycle: a hardware pulse that raises it and a clear write that retires it. The bench drives both in a single cycle on one line, and clears a second bit in that same write. It then reads the pending register one edge later and expects the pulsed bit set and the other bit cleared. A second collision is two or three eligible sources pending together (reset with NMI, or NMI with two maskable lines). These cases are judged edge by edge from the sequence of irq_num values, the return pointers and the status bits.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

   typedef enum logic [1:0] {
      CELL_RSVD,
      CELL_HWONLY,
      CELL_FULL
   } cell_kind_e;

   localparam int unsigned RST_IDX = 0;
   localparam int unsigned NMI_IDX = 1;

   function automatic cell_kind_e kind_of(input int unsigned idx, input int unsigned first_mask);
      if (idx == RST_IDX)
         return CELL_HWONLY;
      else if (idx == NMI_IDX)
         return CELL_FULL;
      else if (idx < first_mask)
         return CELL_RSVD;
      else
         return CELL_FULL;
   endfunction

endpackage

// File: rtl/intc_flag_bank.sv
module intc_flag_bank
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned N          = 16,
   parameter int unsigned FIRST_MASK = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hw_req,
   input  logic         sw_set_en,
   input  logic [N-1:0] sw_set,
   input  logic         sw_clr_en,
   input  logic [N-1:0] sw_clr,
   input  logic [N-1:0] take_clr,
   output logic [N-1:0] flags
);

   for (genvar i = 0; i < N; i++) begin : g_cell
      if (kind_of(i, FIRST_MASK) == CELL_RSVD) begin : g_rsvd
         logic unused_rsvd;
         assign unused_rsvd = ^{hw_req[i], sw_set[i], sw_clr[i], take_clr[i]};
         assign flags[i] = 1'b0;
      end else if (kind_of(i, FIRST_MASK) == CELL_HWONLY) begin : g_hw
         logic q;
         logic unused_soft;
         assign unused_soft = ^{sw_set[i], sw_clr[i]};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= 1'b0;
            else
               q <= hw_req[i] | (q & ~take_clr[i]);
         end
         assign flags[i] = q;
      end else begin : g_full
         logic q;
         logic soft_set;
         logic soft_clr;
         assign soft_set = sw_set_en & sw_set[i];
         assign soft_clr = sw_clr_en & sw_clr[i];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= 1'b0;
            else
               q <= hw_req[i] | soft_set | (q & ~take_clr[i] & ~soft_clr);
         end
         assign flags[i] = q;
      end
   end

endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
   parameter int unsigned N     = 16,
   parameter int unsigned IDX_W = 4
) (
   input  logic [N-1:0]     elig,
   output logic             valid,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (elig[i])
            idx = IDX_W'(i);
      end
   end

   assign valid = |elig;

endmodule

// File: rtl/intc_ctl_regs.sv
module intc_ctl_regs #(
   parameter int unsigned N          = 16,
   parameter int unsigned FIRST_MASK = 4,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned BASE_LSB   = 10
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [N-1:0]               en_wdata,
   input  logic                       wr_stat,
   input  logic [1:0]                 stat_wdata,
   input  logic                       wr_tbl,
   input  logic [ADDR_W-1:0]          tbl_wdata,
   input  logic                       mask_take,
   input  logic                       rti,
   output logic [N-1:0]               en_vec,
   output logic                       nmi_en,
   output logic                       glob_en,
   output logic                       prev_en,
   output logic [ADDR_W-BASE_LSB-1:0] tbl_base
);

   localparam int unsigned RSVD_W = FIRST_MASK - 2;

   logic [N-1:FIRST_MASK] line_en_q;
   logic unused_wdata;

   assign unused_wdata = ^{en_wdata[FIRST_MASK-1:2], en_wdata[0], tbl_wdata[BASE_LSB-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_en_q <= '0;
         nmi_en    <= 1'b0;
         glob_en   <= 1'b0;
         prev_en   <= 1'b0;
         tbl_base  <= '0;
      end else begin
         if (wr_en) begin
            line_en_q <= en_wdata[N-1:FIRST_MASK];
            nmi_en    <= nmi_en | en_wdata[1];
         end
         if (mask_take) begin
            prev_en <= glob_en;
            glob_en <= 1'b0;
         end else if (wr_stat) begin
            glob_en <= stat_wdata[0];
            prev_en <= stat_wdata[1];
         end else if (rti) begin
            glob_en <= prev_en;
         end
         if (wr_tbl)
            tbl_base <= tbl_wdata[ADDR_W-1:BASE_LSB];
      end
   end

   assign en_vec = {line_en_q, {RSVD_W{1'b0}}, nmi_en, 1'b1};

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned NUM_W      = 4,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned SLOT_LSB   = 5,
   parameter int unsigned BASE_LSB   = 10,
   parameter int unsigned FIRST_MASK = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2**NUM_W-1:0]  hw_req,
   input  logic                 wr_en,
   input  logic [2**NUM_W-1:0]  en_wdata,
   input  logic                 wr_set,
   input  logic [2**NUM_W-1:0]  set_wdata,
   input  logic                 wr_clr,
   input  logic [2**NUM_W-1:0]  clr_wdata,
   input  logic                 wr_stat,
   input  logic [1:0]           stat_wdata,
   input  logic                 wr_tbl,
   input  logic [ADDR_W-1:0]    tbl_wdata,
   input  logic                 rti,
   input  logic [ADDR_W-1:0]    nxt_addr,
   output logic [2**NUM_W-1:0]  flag_rd,
   output logic [2**NUM_W-1:0]  en_rd,
   output logic [1:0]           stat_rd,
   output logic [ADDR_W-1:0]    tbl_rd,
   output logic                 take,
   output logic [ADDR_W-1:0]    vec_pc,
   output logic [ADDR_W-1:0]    ret_m,
   output logic [ADDR_W-1:0]    ret_n,
   output logic                 ack,
   output logic [NUM_W-1:0]     irq_num
);

   localparam int unsigned N      = 2 ** NUM_W;
   localparam int unsigned BASE_W = ADDR_W - BASE_LSB;
   localparam logic [NUM_W-1:0] FIRST_IDX = NUM_W'(FIRST_MASK);
   localparam logic [NUM_W-1:0] NMI_NUM   = NUM_W'(NMI_IDX);
   localparam logic [NUM_W-1:0] RST_NUM   = NUM_W'(RST_IDX);

   initial begin
      assert (BASE_LSB >= SLOT_LSB + NUM_W)
         else $error("irq_ctrl: table slots overlap the base field");
      assert (FIRST_MASK >= 3 && FIRST_MASK < N)
         else $error("irq_ctrl: FIRST_MASK out of range");
      assert (ADDR_W > BASE_LSB)
         else $error("irq_ctrl: address narrower than base field");
   end

   logic [N-1:0]      flags;
   logic [N-1:0]      en_vec;
   logic [N-1:0]      elig;
   logic [N-1:0]      take_clr;
   logic              nmi_en;
   logic              glob_en;
   logic              prev_en;
   logic [BASE_W-1:0] tbl_base;
   logic              pick_valid;
   logic [NUM_W-1:0]  pick_idx;
   logic              mask_take;
   logic [ADDR_W-1:0] vec_next;

   intc_flag_bank #(
      .N          (N),
      .FIRST_MASK (FIRST_MASK)
   ) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_req    (hw_req),
      .sw_set_en (wr_set),
      .sw_set    (set_wdata),
      .sw_clr_en (wr_clr),
      .sw_clr    (clr_wdata),
      .take_clr  (take_clr),
      .flags     (flags)
   );

   intc_ctl_regs #(
      .N          (N),
      .FIRST_MASK (FIRST_MASK),
      .ADDR_W     (ADDR_W),
      .BASE_LSB   (BASE_LSB)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .en_wdata   (en_wdata),
      .wr_stat    (wr_stat),
      .stat_wdata (stat_wdata),
      .wr_tbl     (wr_tbl),
      .tbl_wdata  (tbl_wdata),
      .mask_take  (mask_take),
      .rti        (rti),
      .en_vec     (en_vec),
      .nmi_en     (nmi_en),
      .glob_en    (glob_en),
      .prev_en    (prev_en),
      .tbl_base   (tbl_base)
   );

   for (genvar i = 0; i < N; i++) begin : g_elig
      if (i == RST_IDX) begin : g_rst
         assign elig[i] = flags[i];
      end else if (i == NMI_IDX) begin : g_nmi
         assign elig[i] = flags[i] & nmi_en;
      end else if (i < FIRST_MASK) begin : g_rsvd
         assign elig[i] = 1'b0;
      end else begin : g_mask
         assign elig[i] = flags[i] & en_vec[i] & glob_en & nmi_en;
      end
   end

   intc_pick #(
      .N     (N),
      .IDX_W (NUM_W)
   ) u_pick (
      .elig  (elig),
      .valid (pick_valid),
      .idx   (pick_idx)
   );

   assign take_clr  = pick_valid ? ({{(N-1){1'b0}}, 1'b1} << pick_idx) : '0;
   assign mask_take = pick_valid && (pick_idx >= FIRST_IDX);
   assign vec_next  = {tbl_base, {BASE_LSB{1'b0}}} | (ADDR_W'(pick_idx) << SLOT_LSB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take    <= 1'b0;
         ack     <= 1'b0;
         irq_num <= '0;
         vec_pc  <= '0;
         ret_m   <= '0;
         ret_n   <= '0;
      end else begin
         take <= pick_valid;
         ack  <= pick_valid;
         if (pick_valid) begin
            irq_num <= pick_idx;
            vec_pc  <= vec_next;
            if (pick_idx == NMI_NUM)
               ret_n <= nxt_addr;
            else if (pick_idx != RST_NUM)
               ret_m <= nxt_addr;
         end
      end
   end

   assign flag_rd = flags;
   assign en_rd   = en_vec;
   assign stat_rd = {prev_en, glob_en};
   assign tbl_rd  = {tbl_base, {BASE_LSB{1'b0}}};

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
   parameter int unsigned NUM_W      = 4,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned SLOT_LSB   = 5,
   parameter int unsigned FIRST_MASK = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                take,
   input logic [NUM_W-1:0]    irq_num,
   input logic [ADDR_W-1:0]   vec_pc,
   input logic [2**NUM_W-1:0] en_rd,
   input logic [1:0]          stat_rd,
   input logic [ADDR_W-1:0]   tbl_rd,
   input logic                wr_stat,
   input logic                wr_en
);

   localparam logic [NUM_W-1:0] FIRST_IDX = NUM_W'(FIRST_MASK);

   // R3
   a_r3_nmi_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en_rd[1]) |-> en_rd[1]);

   // R4
   a_r4_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (take && irq_num >= FIRST_IDX) |-> ($past(en_rd[1]) && $past(stat_rd[0]) && $past(en_rd[irq_num])));

   // R7
   a_r7_entry_status: assert property (@(posedge clk) disable iff (!rst_n)
      (take && irq_num >= FIRST_IDX) |-> (stat_rd == 2'b10));

   // R9
   a_r9_vector: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (vec_pc == ($past(tbl_rd) + (ADDR_W'(irq_num) << SLOT_LSB))));

   // R2
   a_r2_stat_keeps_en: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_stat) && !$past(wr_en)) |-> $stable(en_rd));

endmodule

bind irq_ctrl irq_ctrl_chk #(
   .NUM_W      (NUM_W),
   .ADDR_W     (ADDR_W),
   .SLOT_LSB   (SLOT_LSB),
   .FIRST_MASK (FIRST_MASK)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .take    (take),
   .irq_num (irq_num),
   .vec_pc  (vec_pc),
   .en_rd   (en_rd),
   .stat_rd (stat_rd),
   .tbl_rd  (tbl_rd),
   .wr_stat (wr_stat),
   .wr_en   (wr_en)
);

// File: tb/tb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] hw_req = '0;
   logic        wr_en = 1'b0;
   logic [15:0] en_wdata = '0;
   logic        wr_set = 1'b0;
   logic [15:0] set_wdata = '0;
   logic        wr_clr = 1'b0;
   logic [15:0] clr_wdata = '0;
   logic        wr_stat = 1'b0;
   logic [1:0]  stat_wdata = '0;
   logic        wr_tbl = 1'b0;
   logic [31:0] tbl_wdata = '0;
   logic        rti = 1'b0;
   logic [31:0] nxt_addr = '0;
   logic [15:0] flag_rd;
   logic [15:0] en_rd;
   logic [1:0]  stat_rd;
   logic [31:0] tbl_rd;
   logic        take;
   logic [31:0] vec_pc;
   logic [31:0] ret_m;
   logic [31:0] ret_n;
   logic        ack;
   logic [3:0]  irq_num;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .hw_req(hw_req),
      .wr_en(wr_en), .en_wdata(en_wdata),
      .wr_set(wr_set), .set_wdata(set_wdata),
      .wr_clr(wr_clr), .clr_wdata(clr_wdata),
      .wr_stat(wr_stat), .stat_wdata(stat_wdata),
      .wr_tbl(wr_tbl), .tbl_wdata(tbl_wdata),
      .rti(rti), .nxt_addr(nxt_addr),
      .flag_rd(flag_rd), .en_rd(en_rd), .stat_rd(stat_rd), .tbl_rd(tbl_rd),
      .take(take), .vec_pc(vec_pc), .ret_m(ret_m), .ret_n(ret_n),
      .ack(ack), .irq_num(irq_num)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic idle();
      hw_req = '0; wr_en = 0; wr_set = 0; wr_clr = 0; wr_stat = 0; wr_tbl = 0; rti = 0;
   endtask

   task automatic t_reset();
      check("R1", "flags", flag_rd, 32'h0);
      check("R1", "enable", en_rd, 32'h0001);
      check("R1", "status", stat_rd, 32'h0);
      check("R1", "table", tbl_rd, 32'h0);
      check("R1", "take", take, 32'h0);
      check("R1", "ack", ack, 32'h0);
   endtask

   task automatic t_gate_and_entry();
      wr_en = 1; en_wdata = 16'hFFF0;
      wr_stat = 1; stat_wdata = 2'b01;
      wr_set = 1; set_wdata = 16'h0080;
      nxt_addr = 32'h0000_4444;
      step(); idle();
      check("R5", "flag after set", flag_rd, 32'h0080);
      check("R2", "enable layout", en_rd, 32'hFFF1);
      check("R2", "status", stat_rd, 32'h1);
      for (int k = 0; k < 3; k++) begin
         step();
         check("R4", "no take without NMI enable", take, 32'h0);
      end
      check("R4", "flag still pending", flag_rd, 32'h0080);
      wr_en = 1; en_wdata = 16'hFFF2;
      step(); idle();
      check("R4", "take waits one edge", take, 32'h0);
      step();
      check("R10", "take", take, 32'h1);
      check("R10", "ack", ack, 32'h1);
      check("R10", "number", irq_num, 32'h7);
      check("R9", "vector", vec_pc, 32'h0000_00E0);
      check("R7", "maskable return", ret_m, 32'h0000_4444);
      check("R7", "status after entry", stat_rd, 32'h2);
      check("R7", "flag retired", flag_rd, 32'h0);
      check("R2", "enable with NMI", en_rd, 32'hFFF3);
      step();
      check("R10", "take single cycle", take, 32'h0);
      check("R10", "ack single cycle", ack, 32'h0);
   endtask

   task automatic t_sticky();
      wr_en = 1; en_wdata = 16'h0000;
      step(); idle();
      check("R3", "NMI enable kept", en_rd, 32'h0003);
      wr_en = 1; en_wdata = 16'hFFF2;
      step(); idle();
      check("R2", "enable restored", en_rd, 32'hFFF3);
      wr_stat = 1; stat_wdata = 2'b01;
      step(); idle();
      check("R2", "status write keeps enable", en_rd, 32'hFFF3);
      wr_stat = 1; stat_wdata = 2'b00;
      step(); idle();
   endtask

   task automatic t_setclr();
      wr_set = 1; set_wdata = 16'h003D;
      #1;
      check("R5", "not before edge", flag_rd, 32'h0);
      step(); idle();
      check("R5", "soft set, bits 0/2/3 untouched", flag_rd, 32'h0030);
      step();
      check("R5", "no reset entry from soft set", take, 32'h0);
      wr_clr = 1; clr_wdata = 16'h0010;
      step(); idle();
      check("R5", "soft clear", flag_rd, 32'h0020);
   endtask

   task automatic t_conflict();
      hw_req = 16'h0040; wr_clr = 1; clr_wdata = 16'h0060;
      step(); idle();
      check("R6", "hardware set beats clear", flag_rd, 32'h0040);
      wr_clr = 1; clr_wdata = 16'h0040;
      step(); idle();
      check("R5", "cleared", flag_rd, 32'h0);
   endtask

   task automatic t_priority_rti();
      nxt_addr = 32'h0000_5555;
      wr_set = 1; set_wdata = 16'h0222;
      wr_stat = 1; stat_wdata = 2'b01;
      step(); idle();
      check("R11", "three pending", flag_rd, 32'h0222);
      check("R11", "no take yet", take, 32'h0);
      step();
      nxt_addr = 32'h0000_6666;
      check("R11", "NMI first", irq_num, 32'h1);
      check("R8", "NMI return", ret_n, 32'h0000_5555);
      check("R8", "maskable return kept", ret_m, 32'h0000_4444);
      check("R8", "status kept", stat_rd, 32'h1);
      step();
      check("R11", "then line 5", irq_num, 32'h5);
      check("R11", "take again", take, 32'h1);
      check("R7", "maskable return", ret_m, 32'h0000_6666);
      check("R7", "status", stat_rd, 32'h2);
      check("R8", "NMI return kept", ret_n, 32'h0000_5555);
      step();
      check("R4", "line 9 held by global enable", take, 32'h0);
      check("R4", "line 9 pending", flag_rd, 32'h0200);
      rti = 1;
      step(); idle();
      check("R12", "global enable restored", stat_rd, 32'h3);
      check("R12", "no take same edge", take, 32'h0);
      step();
      check("R11", "line 9 taken", irq_num, 32'h9);
      check("R9", "vector 9", vec_pc, 32'h0000_0120);
      check("R7", "status", stat_rd, 32'h2);
      step();
   endtask

   task automatic t_table();
      wr_tbl = 1; tbl_wdata = 32'h1234_5BFF;
      step(); idle();
      check("R9", "table low bits zero", tbl_rd, 32'h1234_5800);
      wr_stat = 1; stat_wdata = 2'b01;
      hw_req = 16'h1000; nxt_addr = 32'h0000_7777;
      step(); idle();
      check("R5", "hardware pulse sets flag", flag_rd, 32'h1000);
      step();
      check("R10", "number 12", irq_num, 32'hC);
      check("R9", "relocated vector", vec_pc, 32'h1234_5980);
      check("R7", "maskable return", ret_m, 32'h0000_7777);
      step();
   endtask

   task automatic t_reset_take();
      hw_req = 16'h0003; nxt_addr = 32'h0000_8888;
      step(); idle();
      step();
      check("R11", "reset first", irq_num, 32'h0);
      check("R11", "reset take", take, 32'h1);
      check("R9", "reset vector", vec_pc, 32'h1234_5800);
      check("R8", "reset keeps NMI return", ret_n, 32'h0000_5555);
      check("R8", "reset keeps maskable return", ret_m, 32'h0000_7777);
      step();
      check("R11", "NMI next cycle", irq_num, 32'h1);
      check("R9", "NMI vector", vec_pc, 32'h1234_5820);
      check("R8", "NMI return", ret_n, 32'h0000_8888);
      check("R8", "status untouched", stat_rd, 32'h2);
      step();
      check("R10", "quiet after", take, 32'h0);
   endtask

   initial begin
      repeat (3) step();
      t_reset();
      rst_n = 1;
      step();
      t_reset();
      t_gate_and_entry();
      t_sticky();
      t_setclr();
      t_conflict();
      t_priority_rti();
      t_table();
      t_reset_take();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule